// File: doc/BRIEF.md
# Management Bus Controller with Background PHY Scan

This block sits between a CPU register bus and a serial management frame engine that talks to Ethernet PHYs. Software programs a control word (scan enable and a clock divider for the frame engine) and starts single management transactions through one combined access word. That word carries a start flag, the direction, the PHY and register addresses, the data and the completion status. The start flag clears itself when the transaction is done, so software polls that one word for both completion and result.

While scanning is enabled, a background sequencer reads one fixed PHY register at each PHY address in turn. It records in a 32-bit presence bitmap whether each address answered. Software transactions share the frame engine with the scan. A pending software request never preempts a frame that is already in flight. It is granted the engine as soon as that frame ends, ahead of the next scan read. The frame engine receives one request at a time and holds it until the engine signals completion.

Top module: `phy_mgmt_ctl`

## Requirements
- R1: After reset, word 0 (control) reads 0x800000FF (busy-free flag set, scan off, divider at the reset default 255), word 1 (access) reads 0, word 2 (presence) reads 0, and no frame is requested.
- R2: A bus write to word 0 sets the scan enable from bit 30 and the divider from bits 15:0. The divider appears on `mdc_div`. Bit 31 reads the busy-free status and cannot be written.
- R3: Writing word 1 with bit 31 (start) set issues one frame with the direction from bit 30 (1 = write), register address from bits 25:21, PHY address from bits 20:16 and write data from bits 15:0.
- R4: The start bit reads 1 from the write until the frame completes, and reads 0 once it has completed.
- R5: On completion, bit 29 (acknowledge) takes the engine's acknowledge. For a read, bits 15:0 take the returned data. For a write, the data field is left unchanged.
- R6: Writes to word 1 while the start bit is set are ignored.
- R7: While enabled, the scan issues reads of register `SCAN_REG` (default 1) to PHY addresses 0, 1, … 31 in order, then wraps to 0.
- R8: Each scan read writes the engine's acknowledge into the presence bit of the address read. That bit can be set or cleared.
- R9: Clearing the enable starts no further scan frame. A frame in flight finishes, after which the busy-free bit reads 1 and no frame is requested.
- R10: A software request made during a scan frame waits for that frame to end. It is then issued before the next scan read, and the scan then resumes at the following address.
- R11: A software request is executed even while the scan is disabled.
- R12: The frame request and its fields stay steady from issue until the engine's completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word index: 0 control, 1 access, 2 presence |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| mdc_div | output | 16 | Clock divider setting for the frame engine |
| fe_req | output | 1 | Frame request, held until completion |
| fe_write | output | 1 | Frame direction, 1 = write |
| fe_phy | output | 5 | PHY address of the frame |
| fe_regad | output | 5 | Register address of the frame |
| fe_wdata | output | 16 | Write data of the frame |
| fe_done | input | 1 | One-cycle completion pulse from the engine |
| fe_ack | input | 1 | PHY acknowledged, valid with fe_done |
| fe_rdata | input | 16 | Read result, valid with fe_done |

## Verification
On every cycle, the assertions check four things: frame fields stay steady until completion, the start bit stays high for the life of a software frame and drops once it completes, accesses written while busy leave the stored request intact, and a pending request wins the next free slot and no scan frame starts with the enable clear. The bench's scenarios cover the parts that need a PHY model with a chosen set of answering addresses. These are the exact address order of a full scan sweep with its wrap, the presence bitmap built against that set and then rebuilt after the set shrinks, and the returned read data and acknowledge landing in the access word. They also cover a software write injected in the middle of a scan frame, whose ordering is checked against the scan addresses before and after it.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int PHY_AW = 5;
    localparam int REG_AW = 5;
    localparam int MD_DW  = 16;
    localparam int N_PHY  = 1 << PHY_AW;
    localparam int WORD_W = 32;

    // bit positions in the control and access words
    localparam int CTL_FREE_BIT = 31;
    localparam int CTL_EN_BIT   = 30;
    localparam int ACC_GO_BIT   = 31;
    localparam int ACC_WR_BIT   = 30;
    localparam int ACC_ACK_BIT  = 29;
    localparam int ACC_REG_LSB  = 21;
    localparam int ACC_PHY_LSB  = 16;

    // word indices on the register bus
    localparam int WI_CTRL     = 0;
    localparam int WI_ACCESS   = 1;
    localparam int WI_PRESENCE = 2;

    typedef struct packed {
        logic              wr;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
        logic [MD_DW-1:0]  data;
    } mgmt_op_t;

    typedef enum logic { SQ_IDLE = 1'b0, SQ_BUSY = 1'b1 } sq_state_t;
endpackage

// File: rtl/mgmt_scan_ptr.sv
module mgmt_scan_ptr
    import phy_mgmt_pkg::*;
#(
    parameter int AW = PHY_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } sp_state_t;

    sp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.ptr = st_q.ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
    import phy_mgmt_pkg::*;
#(
    parameter logic [REG_AW-1:0] SCAN_REG = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_go,
    input  mgmt_op_t          user_op,
    input  logic              scan_en,
    input  logic [PHY_AW-1:0] scan_phy,
    input  logic              fe_done,
    output logic              fe_req,
    output mgmt_op_t          fe_op,
    output logic              busy,
    output logic              owner_user,
    output logic              done_user,
    output logic              done_scan
);
    typedef struct packed {
        sq_state_t st;
        logic      owner;
        mgmt_op_t  op;
    } seq_state_t;

    seq_state_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        done_user = 1'b0;
        done_scan = 1'b0;
        unique case (sq_q.st)
            SQ_IDLE: begin
                // a pending software request wins over the next scan read
                if (user_go) begin
                    sq_d.st    = SQ_BUSY;
                    sq_d.owner = 1'b1;
                    sq_d.op    = user_op;
                end else if (scan_en) begin
                    sq_d.st       = SQ_BUSY;
                    sq_d.owner    = 1'b0;
                    sq_d.op.wr    = 1'b0;
                    sq_d.op.phy   = scan_phy;
                    sq_d.op.regad = SCAN_REG;
                    sq_d.op.data  = '0;
                end
            end
            SQ_BUSY: begin
                if (fe_done) begin
                    sq_d.st   = SQ_IDLE;
                    done_user = sq_q.owner;
                    done_scan = !sq_q.owner;
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, owner: 1'b0, op: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign fe_req     = (sq_q.st == SQ_BUSY);
    assign busy       = fe_req;
    assign fe_op      = sq_q.op;
    assign owner_user = sq_q.owner;
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int          BUS_AW    = 2,
    parameter logic [15:0] DIV_RESET = 16'd255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              seq_busy,
    input  logic              done_user,
    input  logic              done_scan,
    input  logic [PHY_AW-1:0] done_phy,
    input  logic              fe_ack,
    input  logic [MD_DW-1:0]  fe_rdata,
    output logic              enable,
    output logic [15:0]       div,
    output logic              user_go,
    output mgmt_op_t          user_op
);
    typedef struct packed {
        logic             en;
        logic [15:0]      div;
        logic             go;
        logic             ack;
        mgmt_op_t         op;
        logic [N_PHY-1:0] alive;
    } reg_state_t;

    reg_state_t rg_d, rg_q;

    logic wr_ctrl, wr_acc;
    logic unused_wbits;

    assign wr_ctrl      = bus_wr && (bus_addr == BUS_AW'(WI_CTRL));
    assign wr_acc       = bus_wr && (bus_addr == BUS_AW'(WI_ACCESS));
    assign unused_wbits = ^{bus_wdata[28:26], bus_wdata[29:16], bus_wdata[ACC_ACK_BIT]};

    always_comb begin
        rg_d = rg_q;
        if (wr_ctrl) begin
            rg_d.en  = bus_wdata[CTL_EN_BIT];
            rg_d.div = bus_wdata[15:0];
        end
        // the access word is locked while a request is outstanding
        if (wr_acc && !rg_q.go) begin
            rg_d.go       = bus_wdata[ACC_GO_BIT];
            rg_d.ack      = 1'b0;
            rg_d.op.wr    = bus_wdata[ACC_WR_BIT];
            rg_d.op.regad = bus_wdata[ACC_REG_LSB +: REG_AW];
            rg_d.op.phy   = bus_wdata[ACC_PHY_LSB +: PHY_AW];
            rg_d.op.data  = bus_wdata[MD_DW-1:0];
        end
        if (done_user) begin
            rg_d.go  = 1'b0;
            rg_d.ack = fe_ack;
            if (!rg_q.op.wr) begin
                rg_d.op.data = fe_rdata;
            end
        end
        if (done_scan) begin
            rg_d.alive[done_phy] = fe_ack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{en: 1'b0, div: DIV_RESET, go: 1'b0, ack: 1'b0, op: '0, alive: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BUS_AW'(WI_CTRL)) begin
            bus_rdata = {!seq_busy, rg_q.en, 14'b0, rg_q.div};
        end else if (bus_addr == BUS_AW'(WI_ACCESS)) begin
            bus_rdata = {rg_q.go, rg_q.op.wr, rg_q.ack, 3'b0,
                         rg_q.op.regad, rg_q.op.phy, rg_q.op.data};
        end else if (bus_addr == BUS_AW'(WI_PRESENCE)) begin
            bus_rdata = rg_q.alive;
        end
    end

    assign enable  = rg_q.en;
    assign div     = rg_q.div;
    assign user_go = rg_q.go;
    assign user_op = rg_q.op;
endmodule

// File: rtl/phy_mgmt_ctl.sv
module phy_mgmt_ctl
    import phy_mgmt_pkg::*;
#(
    parameter int          BUS_AW    = 2,
    parameter logic [15:0] DIV_RESET = 16'd255,
    parameter logic [4:0]  SCAN_REG  = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [15:0]       mdc_div,
    output logic              fe_req,
    output logic              fe_write,
    output logic [4:0]        fe_phy,
    output logic [4:0]        fe_regad,
    output logic [15:0]       fe_wdata,
    input  logic              fe_done,
    input  logic              fe_ack,
    input  logic [15:0]       fe_rdata
);
    logic              ctl_enable;
    logic              user_go;
    mgmt_op_t          user_op;
    mgmt_op_t          fe_op;
    logic              seq_busy;
    logic              seq_owner_user;
    logic              done_user;
    logic              done_scan;
    logic [PHY_AW-1:0] scan_phy;
    logic              user_wr_f;
    logic [PHY_AW-1:0] user_phy_f;
    logic [REG_AW-1:0] user_reg_f;

    mgmt_regs #(
        .BUS_AW   (BUS_AW),
        .DIV_RESET(DIV_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .seq_busy (seq_busy),
        .done_user(done_user),
        .done_scan(done_scan),
        .done_phy (fe_op.phy),
        .fe_ack   (fe_ack),
        .fe_rdata (fe_rdata),
        .enable   (ctl_enable),
        .div      (mdc_div),
        .user_go  (user_go),
        .user_op  (user_op)
    );

    mgmt_scan_ptr #(.AW(PHY_AW)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (done_scan),
        .ptr  (scan_phy)
    );

    mgmt_seq #(.SCAN_REG(SCAN_REG)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_go   (user_go),
        .user_op   (user_op),
        .scan_en   (ctl_enable),
        .scan_phy  (scan_phy),
        .fe_done   (fe_done),
        .fe_req    (fe_req),
        .fe_op     (fe_op),
        .busy      (seq_busy),
        .owner_user(seq_owner_user),
        .done_user (done_user),
        .done_scan (done_scan)
    );

    assign fe_write   = fe_op.wr;
    assign fe_phy     = fe_op.phy;
    assign fe_regad   = fe_op.regad;
    assign fe_wdata   = fe_op.data;
    assign user_wr_f  = user_op.wr;
    assign user_phy_f = user_op.phy;
    assign user_reg_f = user_op.regad;
endmodule

// File: rtl/phy_mgmt_ctl_chk.sv
module phy_mgmt_ctl_chk #(
    parameter int BUS_AW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fe_req,
    input logic              fe_done,
    input logic              fe_write,
    input logic [4:0]        fe_phy,
    input logic [4:0]        fe_regad,
    input logic [15:0]       fe_wdata,
    input logic              go,
    input logic              owner_user,
    input logic              enable,
    input logic              seq_busy,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              user_wr,
    input logic [4:0]        user_phy,
    input logic [4:0]        user_regad
);
    assert_frame_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fe_req && !fe_done |=> fe_req && $stable(fe_write) && $stable(fe_phy)
                                && $stable(fe_regad) && $stable(fe_wdata));

    assert_go_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fe_req && owner_user |-> go);

    assert_go_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fe_req && fe_done && owner_user |=> !go);

    assert_locked_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        go && bus_wr && (bus_addr == BUS_AW'(1)) |=>
            $stable(user_wr) && $stable(user_phy) && $stable(user_regad));

    assert_no_scan_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_req) && !$past(enable) |-> owner_user);

    assert_user_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy && go |=> fe_req && owner_user);
endmodule

bind phy_mgmt_ctl phy_mgmt_ctl_chk #(.BUS_AW(BUS_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fe_req    (fe_req),
    .fe_done   (fe_done),
    .fe_write  (fe_write),
    .fe_phy    (fe_phy),
    .fe_regad  (fe_regad),
    .fe_wdata  (fe_wdata),
    .go        (user_go),
    .owner_user(seq_owner_user),
    .enable    (ctl_enable),
    .seq_busy  (seq_busy),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .user_wr   (user_wr_f),
    .user_phy  (user_phy_f),
    .user_regad(user_reg_f)
);

// File: tb/phy_mgmt_ctl_test.sv
`timescale 1ns/1ps
module phy_mgmt_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] mdc_div;
    logic        fe_req, fe_write;
    logic [4:0]  fe_phy, fe_regad;
    logic [15:0] fe_wdata;
    logic        fe_done = 1'b0;
    logic        fe_ack = 1'b0;
    logic [15:0] fe_rdata = '0;

    int checks = 0;
    int errors = 0;
    int n_txn = 0;
    logic [31:0] phy_mask = '0;
    localparam int LAT = 6;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
    } item_t;
    item_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    phy_mgmt_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc_div(mdc_div),
        .fe_req(fe_req), .fe_write(fe_write), .fe_phy(fe_phy), .fe_regad(fe_regad),
        .fe_wdata(fe_wdata), .fe_done(fe_done), .fe_ack(fe_ack), .fe_rdata(fe_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_answer(input logic [4:0] p, input logic [4:0] r);
        return {p, r, 6'h15};
    endfunction

    // frame engine model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (fe_req) begin
                n_txn++;
                if (exp_q.size() > 0) begin
                    item_t e;
                    item_t a;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    a = '{wr: fe_write, phy: fe_phy, rg: fe_regad, wd: (fe_write ? fe_wdata : 16'h0)};
                    if (!e.wr) e.wd = 16'h0;
                    chk(a == e, t, 32'(a), 32'(e));
                end
                fe_ack   = phy_mask[fe_phy];
                fe_rdata = phy_answer(fe_phy, fe_regad);
                repeat (LAT - 1) @(negedge clk);
                fe_done = 1'b1;
                @(negedge clk);
                fe_done = 1'b0;
                fe_ack  = 1'b0;
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic push_exp(input logic wr, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] wd, input string t);
        exp_q.push_back('{wr: wr, phy: p, rg: r, wd: wd});
        tag_q.push_back(t);
    endtask

    // driver: expects the frame, then starts it
    task automatic user_req(input logic wr, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] wd, input string t);
        push_exp(wr, p, r, wd, t);
        bus_write(2'd1, {1'b1, wr, 1'b0, 3'b0, r, p, wd});
    endtask

    task automatic wait_go_clear();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            bus_read(2'd1, v);
            if (!v[31]) break;
        end
    endtask

    task automatic wait_free();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            bus_read(2'd0, v);
            if (v[31]) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        logic [4:0] nxt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(2'd0, v); chk(v == 32'h800000FF, "R1 control", v, 32'h800000FF);
        bus_read(2'd1, v); chk(v == 32'h0, "R1 access", v, 32'h0);
        bus_read(2'd2, v); chk(v == 32'h0, "R1 presence", v, 32'h0);
        chk(fe_req == 1'b0, "R1 no frame", 32'(fe_req), 32'h0);

        // R2: divider and read-only free bit
        bus_write(2'd0, 32'h8000_0013);
        bus_read(2'd0, v); chk(v == 32'h8000_0013, "R2 control", v, 32'h8000_0013);
        chk(mdc_div == 16'h0013, "R2 mdc_div", 32'(mdc_div), 32'h13);
        bus_write(2'd0, 32'h0000_0013);
        bus_read(2'd0, v); chk(v[31] == 1'b1, "R2 free bit not writable", v, 32'h8000_0013);

        // R3 R4 R5 R11 R6: user read with scan disabled
        phy_mask = 32'h0000_0024;
        user_req(1'b0, 5'd5, 5'd3, 16'h0, "R3 R11 user read frame");
        bus_read(2'd1, v); chk(v[31] == 1'b1, "R4 start bit held", v, 32'h8000_0000);
        bus_write(2'd1, {1'b1, 1'b1, 1'b0, 3'b0, 5'd7, 5'd9, 16'hAAAA}); // R6: ignored
        wait_go_clear();
        bus_read(2'd1, v);
        chk(v == {1'b0, 1'b0, 1'b1, 3'b0, 5'd3, 5'd5, phy_answer(5'd5, 5'd3)},
            "R5 R6 read result", v, {1'b0, 1'b0, 1'b1, 3'b0, 5'd3, 5'd5, phy_answer(5'd5, 5'd3)});
        chk(exp_q.size() == 0, "R6 single frame", 32'(exp_q.size()), 32'h0);

        // R5: write to a silent PHY, data kept, no acknowledge
        user_req(1'b1, 5'd9, 5'd7, 16'hBEEF, "R3 user write frame");
        wait_go_clear();
        bus_read(2'd1, v);
        chk(v == {1'b0, 1'b1, 1'b0, 3'b0, 5'd7, 5'd9, 16'hBEEF}, "R5 write no ack", v,
            {1'b0, 1'b1, 1'b0, 3'b0, 5'd7, 5'd9, 16'hBEEF});

        // R7 R8: full sweep plus wrap
        phy_mask = 32'h8000_0421;
        for (int i = 0; i < 34; i++) push_exp(1'b0, 5'(i % 32), 5'd1, 16'h0, "R7 scan order");
        bus_write(2'd0, 32'h4000_0013);
        while (exp_q.size() > 0) @(negedge clk);
        bus_write(2'd0, 32'h0000_0013);
        wait_free();
        bus_read(2'd2, v); chk(v == 32'h8000_0421, "R8 presence", v, 32'h8000_0421);

        // R9: nothing after disable
        base = n_txn;
        repeat (60) @(negedge clk);
        chk(n_txn == base && !fe_req, "R9 scan stopped", 32'(n_txn - base), 32'h0);
        bus_read(2'd0, v); chk(v[31] == 1'b1, "R9 free bit", v, 32'h8000_0013);

        // R8: bits clear when PHYs go silent
        phy_mask = 32'h0000_0022;
        base = n_txn;
        bus_write(2'd0, 32'h4000_0013);
        while (n_txn < base + 33) @(negedge clk);
        bus_write(2'd0, 32'h0000_0013);
        wait_free();
        bus_read(2'd2, v); chk(v == 32'h0000_0022, "R8 presence cleared", v, 32'h22);

        // R10: user write injected mid scan frame
        bus_write(2'd0, 32'h4000_0013);
        @(negedge clk);
        while (!fe_req) @(negedge clk);
        nxt = fe_phy + 5'd1;
        @(negedge clk);
        user_req(1'b1, 5'd5, 5'd4, 16'h1234, "R10 user before next scan");
        push_exp(1'b0, nxt, 5'd1, 16'h0, "R10 scan resumes");
        while (exp_q.size() > 0) @(negedge clk);
        bus_write(2'd0, 32'h0000_0013);
        wait_free();
        bus_read(2'd1, v);
        chk(v == {1'b0, 1'b1, 1'b1, 3'b0, 5'd4, 5'd5, 16'h1234}, "R10 user done", v,
            {1'b0, 1'b1, 1'b1, 3'b0, 5'd4, 5'd5, 16'h1234});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule